// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits on a simple 32-bit register bus and fronts an array of one-time-programmable fuse words. Software selects a word and a bit position through control registers, sets a data-in value and fires a program operation by writing the write-enable register. Each bit can be programmed once. A per-bit written map rejects any later attempt on the same bit and raises a one-cycle error pulse. The addressed word is read through a data-out register. It returns real fuse content only while three enable registers (chip enable, strobe and trim) all have bit 0 set. Otherwise it returns 0xFF.

After reset, the block runs an initialisation sweep over the whole array before it accepts bus traffic. The sweep sets every word to all ones and clears every written flag. It loads a configurable serial number at a fixed word index and the bitwise complement of that number into the following word. All accesses are full 32-bit words. Every accepted request gets a registered response one cycle later.

Top module: `fuse_ctrl`

## Requirements
- R1: `req_ready` is low for the first DEPTH cycles after reset, while the array is initialised. From then on, every accepted request (`req_valid` and `req_ready`) produces `rsp_valid` on exactly the next cycle and on no other cycle. A write's response data is zero.
- R2: After initialisation, every fuse word reads as 0xFFFFFFFF, except the two serial words.
- R3: The word at SERIAL_IDX holds SERIAL_VAL, and the word at SERIAL_IDX+1 holds its bitwise complement.
- R4: A read of DOUT (offset 0x20) returns the word at the current ADDR only when bit 0 of CE (0x0C), STB (0x10) and TRIM (0x14) is set in all three. Otherwise it returns 0x000000FF.
- R5: A write to ADDR (0x00) keeps only the low log2(DEPTH) bits, where DEPTH is a power of two. Reading ADDR returns the masked index.
- R6: A write to WEN (0x1C) stores only bit 0. If that bit is 1 and RED (0x18) is zero, bit BIT[4:0] (BIT at 0x04) of the addressed word is set when DIN (0x08) is nonzero and cleared when DIN is zero.
- R7: Each programmed bit is marked written. A later program of a marked bit leaves the word unchanged and raises `err_o` for one cycle, together with that write's response.
- R8: While RED is nonzero, a WEN write with bit 0 set changes no fuse bit, marks nothing and raises no error.
- R9: A write to DOUT has no effect on fuse content or registers and raises no error.
- R10: BIT, DIN, CE, STB, TRIM, RED and the plain storage registers read back the last value written, all 32 bits, and read zero after reset. The plain storage registers are CLKC 0x24, PROGC 0x28, TSTM 0x2C, TSTR 0x30 and RPR 0x34.
- R11: Unmapped or unaligned offsets read zero. A write to one raises `err_o` for one cycle and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can accept a request (low during initialisation) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | OFF_W (8) | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| err_o | output | 1 | One-cycle error: unmapped write or rejected reprogram |

## Verification
Directed sequences program bits in both directions: clearing a bit of an all-ones word, and setting a bit that is zero in the serial word. These show that DIN chooses the bit value and that only the selected bit changes. Repeating a program on the same bit with the opposite value separates a real write-once lock from a design that just rewrites the value. Programming with RED nonzero and then again with RED zero shows that the blocked attempt left no written flag. Random traffic over a few colliding word indices mixes enable patterns, bit indices above 31, zero and nonzero DIN, and stray offsets. This exposes mistakes in gating, in bit-index truncation and in the written map.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 8;
  localparam int BIT_W  = $clog2(DATA_W);

  localparam logic [OFF_W-1:0] OFS_ADDR  = 8'h00;
  localparam logic [OFF_W-1:0] OFS_BIT   = 8'h04;
  localparam logic [OFF_W-1:0] OFS_DIN   = 8'h08;
  localparam logic [OFF_W-1:0] OFS_CE    = 8'h0C;
  localparam logic [OFF_W-1:0] OFS_STB   = 8'h10;
  localparam logic [OFF_W-1:0] OFS_TRIM  = 8'h14;
  localparam logic [OFF_W-1:0] OFS_RED   = 8'h18;
  localparam logic [OFF_W-1:0] OFS_WEN   = 8'h1C;
  localparam logic [OFF_W-1:0] OFS_DOUT  = 8'h20;
  localparam logic [OFF_W-1:0] OFS_CLKC  = 8'h24;
  localparam logic [OFF_W-1:0] OFS_PROGC = 8'h28;
  localparam logic [OFF_W-1:0] OFS_TSTM  = 8'h2C;
  localparam logic [OFF_W-1:0] OFS_TSTR  = 8'h30;
  localparam logic [OFF_W-1:0] OFS_RPR   = 8'h34;

  localparam logic [DATA_W-1:0] DOUT_BLOCKED = 32'h0000_00FF;

  // Content a word holds once the init sweep has visited it.
  function automatic logic [DATA_W-1:0] preload_word(input int unsigned idx,
                                                     input int unsigned sidx,
                                                     input logic [DATA_W-1:0] serial);
    if (idx == sidx)           return serial;
    else if (idx == sidx + 1)  return ~serial;
    else                       return '1;
  endfunction

  // Fuse content is visible only with all three enables set.
  function automatic logic read_gate(input logic [DATA_W-1:0] ce,
                                     input logic [DATA_W-1:0] stb,
                                     input logic [DATA_W-1:0] trim);
    return ce[0] & stb[0] & trim[0];
  endfunction

  function automatic logic offset_mapped(input logic [OFF_W-1:0] off);
    case (off)
      OFS_ADDR, OFS_BIT, OFS_DIN, OFS_CE, OFS_STB, OFS_TRIM, OFS_RED, OFS_WEN,
      OFS_DOUT, OFS_CLKC, OFS_PROGC, OFS_TSTM, OFS_TSTR, OFS_RPR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_pkg::*;
#(
  parameter int DEPTH = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc,
  input  logic                    wr,
  input  logic [OFF_W-1:0]        off,
  input  logic [DATA_W-1:0]       wdata,
  output logic [$clog2(DEPTH)-1:0] addr_q,
  output logic [BIT_W-1:0]        prog_bit,
  output logic                    prog_val,
  output logic                    prog_fire,
  output logic                    gate,
  output logic                    unmapped_wr,
  output logic [DATA_W-1:0]       rd_val
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] bit_q, din_q, ce_q, stb_q, trim_q, red_q;
  logic [DATA_W-1:0] clkc_q, progc_q, tstm_q, tstr_q, rpr_q;
  logic              wen_q;
  logic              wr_acc;

  assign wr_acc = acc & wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; bit_q <= '0; din_q <= '0; ce_q <= '0; stb_q <= '0;
      trim_q <= '0; red_q <= '0; clkc_q <= '0; progc_q <= '0;
      tstm_q <= '0; tstr_q <= '0; rpr_q <= '0; wen_q <= 1'b0;
    end else if (wr_acc) begin
      case (off)
        OFS_ADDR:  addr_q  <= wdata[IDX_W-1:0];
        OFS_BIT:   bit_q   <= wdata;
        OFS_DIN:   din_q   <= wdata;
        OFS_CE:    ce_q    <= wdata;
        OFS_STB:   stb_q   <= wdata;
        OFS_TRIM:  trim_q  <= wdata;
        OFS_RED:   red_q   <= wdata;
        OFS_WEN:   wen_q   <= wdata[0];
        OFS_CLKC:  clkc_q  <= wdata;
        OFS_PROGC: progc_q <= wdata;
        OFS_TSTM:  tstm_q  <= wdata;
        OFS_TSTR:  tstr_q  <= wdata;
        OFS_RPR:   rpr_q   <= wdata;
        default:   ;
      endcase
    end
  end

  assign prog_bit    = bit_q[BIT_W-1:0];
  assign prog_val    = |din_q;
  assign prog_fire   = wr_acc & (off == OFS_WEN) & wdata[0] & (red_q == '0);
  assign gate        = read_gate(ce_q, stb_q, trim_q);
  assign unmapped_wr = wr_acc & ~offset_mapped(off);

  always_comb begin
    case (off)
      OFS_ADDR:  rd_val = {{(DATA_W-IDX_W){1'b0}}, addr_q};
      OFS_BIT:   rd_val = bit_q;
      OFS_DIN:   rd_val = din_q;
      OFS_CE:    rd_val = ce_q;
      OFS_STB:   rd_val = stb_q;
      OFS_TRIM:  rd_val = trim_q;
      OFS_RED:   rd_val = red_q;
      OFS_WEN:   rd_val = {{(DATA_W-1){1'b0}}, wen_q};
      OFS_CLKC:  rd_val = clkc_q;
      OFS_PROGC: rd_val = progc_q;
      OFS_TSTM:  rd_val = tstm_q;
      OFS_TSTR:  rd_val = tstr_q;
      OFS_RPR:   rd_val = rpr_q;
      default:   rd_val = '0;
    endcase
  end
endmodule

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_pkg::*;
#(
  parameter int              DEPTH      = 4096,
  parameter int              SERIAL_IDX = 252,
  parameter logic [DATA_W-1:0] SERIAL_VAL = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  input  logic                     prog_fire,
  input  logic [$clog2(DEPTH)-1:0] prog_idx,
  input  logic [BIT_W-1:0]         prog_bit,
  input  logic                     prog_val,
  output logic                     init_busy,
  output logic [DATA_W-1:0]        rd_word_q,
  output logic                     prog_commit,
  output logic                     prog_reject
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q  [DEPTH];
  logic [DATA_W-1:0] wmap_q [DEPTH];
  logic [IDX_W-1:0]  init_cnt_q;
  logic              busy_q;
  logic              already_written;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b1;
      init_cnt_q <= '0;
    end else if (busy_q) begin
      init_cnt_q <= init_cnt_q + 1'b1;
      if (init_cnt_q == LAST_IDX) busy_q <= 1'b0;
    end
  end

  assign init_busy       = busy_q;
  assign already_written = wmap_q[prog_idx][prog_bit];
  assign prog_commit     = prog_fire & ~busy_q & ~already_written;
  assign prog_reject     = prog_fire & ~busy_q & already_written;

  always_ff @(posedge clk) begin
    if (busy_q) begin
      mem_q[init_cnt_q]  <= preload_word(32'(init_cnt_q), SERIAL_IDX, SERIAL_VAL);
      wmap_q[init_cnt_q] <= '0;
    end else if (prog_commit) begin
      mem_q[prog_idx][prog_bit]  <= prog_val;
      wmap_q[prog_idx][prog_bit] <= 1'b1;
    end
    rd_word_q <= mem_q[rd_idx];
  end
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int                DEPTH      = 4096,
  parameter int                SERIAL_IDX = 252,
  parameter logic [DATA_W-1:0] SERIAL_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              acc;
  logic [IDX_W-1:0]  addr_q;
  logic [BIT_W-1:0]  prog_bit;
  logic              prog_val, prog_fire, read_gate_w, unmapped_wr;
  logic [DATA_W-1:0] rd_val, rd_word;
  logic              init_busy, prog_commit, prog_reject;

  logic              rsp_valid_q, dout_sel_q, gate_q, err_q;
  logic [DATA_W-1:0] regval_q;

  assign req_ready = ~init_busy;
  assign acc       = req_valid & req_ready;

  fuse_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr(req_write), .off(req_off),
    .wdata(req_wdata), .addr_q(addr_q), .prog_bit(prog_bit), .prog_val(prog_val),
    .prog_fire(prog_fire), .gate(read_gate_w), .unmapped_wr(unmapped_wr),
    .rd_val(rd_val)
  );

  fuse_array #(.DEPTH(DEPTH), .SERIAL_IDX(SERIAL_IDX), .SERIAL_VAL(SERIAL_VAL)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_idx(addr_q), .prog_fire(prog_fire),
    .prog_idx(addr_q), .prog_bit(prog_bit), .prog_val(prog_val),
    .init_busy(init_busy), .rd_word_q(rd_word), .prog_commit(prog_commit),
    .prog_reject(prog_reject)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      dout_sel_q  <= 1'b0;
      gate_q      <= 1'b0;
      err_q       <= 1'b0;
      regval_q    <= '0;
    end else begin
      rsp_valid_q <= acc;
      dout_sel_q  <= acc & ~req_write & (req_off == OFS_DOUT);
      gate_q      <= read_gate_w;
      err_q       <= unmapped_wr | prog_reject;
      regval_q    <= (acc & ~req_write) ? rd_val : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = dout_sel_q ? (gate_q ? rd_word : DOUT_BLOCKED) : regval_q;
  assign err_o     = err_q;
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk
  import fuse_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc,
  input logic              req_write,
  input logic [OFF_W-1:0]  req_off,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              err_o,
  input logic              read_gate_w,
  input logic              prog_reject
);
  p_rsp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_rsp_only_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  p_write_rsp_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> (rsp_rdata == '0));
  p_gate_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_off == OFS_DOUT && !read_gate_w) |=> (rsp_rdata == DOUT_BLOCKED));
  p_reject_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_reject |=> err_o);
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(acc && req_write));
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && !offset_mapped(req_off)) |=> (rsp_rdata == '0));
  p_unmapped_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !offset_mapped(req_off)) |=> err_o);
endmodule

bind fuse_ctrl fuse_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .req_write(req_write), .req_off(req_off),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_o(err_o),
  .read_gate_w(read_gate_w), .prog_reject(prog_reject)
);

// File: tb/fuse_ctrl_tb.sv
module fuse_ctrl_tb;
  localparam int          DEPTH = 256;
  localparam int          SIDX  = 200;
  localparam logic [31:0] SVAL  = 32'hA5C3_0F1E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_off = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, err_o;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;

  fuse_ctrl #(.DEPTH(DEPTH), .SERIAL_IDX(SIDX), .SERIAL_VAL(SVAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_off(req_off), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_o(err_o)
  );

  always #4 clk = ~clk;

  // Bench model
  logic [31:0] m_mem [DEPTH];
  logic [31:0] m_wmap [DEPTH];
  logic [31:0] m_reg [8'h38];

  function automatic bit is_mapped(input logic [7:0] o);
    return (o[1:0] == 2'b00) && (o <= 8'h34);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] o);
    if (!is_mapped(o)) return 32'h0;
    if (o == 8'h20) begin
      if (m_reg[8'h0C][0] && m_reg[8'h10][0] && m_reg[8'h14][0])
        return m_mem[m_reg[8'h00][7:0]];
      return 32'hFF;
    end
    return m_reg[o];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [7:0] o, input logic [31:0] d,
                     output logic [31:0] rd, output logic er, output logic vl);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_off = o; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = err_o; vl = rsp_valid;
  endtask

  task automatic do_write(input logic [7:0] o, input logic [31:0] d, input string tag);
    logic [31:0] rd; logic er, vl, exp_err;
    logic [7:0] a; logic [4:0] b;
    a = m_reg[8'h00][7:0]; b = m_reg[8'h04][4:0];
    exp_err = !is_mapped(o) ||
              (o == 8'h1C && d[0] && m_reg[8'h18] == 0 && m_wmap[a][b]);
    bus(1'b1, o, d, rd, er, vl);
    check(vl === 1'b1 && rd === 32'h0, {"R1 write rsp ", tag}, rd, 32'h0);
    check(er === exp_err, {"err ", tag}, {31'h0, er}, {31'h0, exp_err});
    if (is_mapped(o)) begin
      case (o)
        8'h00: m_reg[o] = d & (DEPTH - 1);
        8'h1C: begin
          m_reg[o] = {31'h0, d[0]};
          if (d[0] && m_reg[8'h18] == 0 && !m_wmap[a][b]) begin
            m_mem[a][b] = (m_reg[8'h08] != 0);
            m_wmap[a][b] = 1'b1;
          end
        end
        8'h20: ;
        default: m_reg[o] = d;
      endcase
    end
  endtask

  task automatic do_read(input logic [7:0] o, input string tag);
    logic [31:0] rd, exp; logic er, vl;
    exp = exp_read(o);
    bus(1'b0, o, 32'h0, rd, er, vl);
    check(vl === 1'b1 && er === 1'b0, {"R1 read rsp ", tag}, {30'h0, vl, er}, 32'h2);
    check(rd === exp, {"read ", tag}, rd, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [7:0] pick_idx [5];
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      m_mem[i] = (i == SIDX) ? SVAL : (i == SIDX + 1) ? ~SVAL : 32'hFFFF_FFFF;
      m_wmap[i] = '0;
    end
    for (int i = 0; i < 8'h38; i++) m_reg[i] = '0;
    pick_idx[0] = 8'd3; pick_idx[1] = 8'd17; pick_idx[2] = 8'(SIDX);
    pick_idx[3] = 8'(SIDX + 1); pick_idx[4] = 8'd255;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b0, "R1 not ready during init", {31'h0, req_ready}, 32'h0);
    check(rsp_valid === 1'b0 && err_o === 1'b0, "R1 reset outputs idle",
          {30'h0, rsp_valid, err_o}, 32'h0);
    cyc = 1;
    while (!req_ready && cyc < 2 * DEPTH) begin @(negedge clk); cyc++; end
    check(cyc >= DEPTH - 1 && cyc <= DEPTH + 1, "R1 init length", cyc, DEPTH);

    // R10 reset values of the registers
    for (int o = 0; o <= 8'h34; o += 4) if (o != 8'h20) do_read(8'(o), "R10 reset value");

    // R2, R3: full content sweep
    do_write(8'h0C, 32'h1, "R4 ce"); do_write(8'h10, 32'h1, "R4 stb");
    do_write(8'h14, 32'h1, "R4 trim");
    for (int i = 0; i < DEPTH; i++) begin
      do_write(8'h00, 32'(i), "R5 addr");
      do_read(8'h20, (i == SIDX || i == SIDX + 1) ? "R3 serial word" : "R2 init word");
    end

    // R4 gating, each enable alone off
    do_write(8'h00, 32'(SIDX), "R5 addr");
    do_write(8'h0C, 32'hFFFF_FFFE, "R4 ce bit0 off"); do_read(8'h20, "R4 gated by ce");
    do_write(8'h0C, 32'h1, "R4 ce"); do_write(8'h10, 32'h0, "R4 stb off");
    do_read(8'h20, "R4 gated by stb");
    do_write(8'h10, 32'h3, "R4 stb"); do_write(8'h14, 32'h2, "R4 trim bit0 off");
    do_read(8'h20, "R4 gated by trim");
    do_write(8'h14, 32'h1, "R4 trim"); do_read(8'h20, "R4 open");

    // R5 mask
    do_write(8'h00, 32'hFFFF_FF05, "R5 masked addr"); do_read(8'h00, "R5 addr readback");

    // R6 clear a bit, R7 reprogram rejected
    do_write(8'h00, 32'd3, "R6 addr"); do_write(8'h04, 32'd4, "R6 bit");
    do_write(8'h08, 32'd0, "R6 din0"); do_write(8'h1C, 32'h1, "R6 program clear");
    do_read(8'h20, "R6 bit cleared"); do_read(8'h1C, "R6 wen readback");
    do_write(8'h08, 32'h100, "R7 din1"); do_write(8'h1C, 32'h1, "R7 reprogram");
    do_read(8'h20, "R7 unchanged after reject");
    // R6 set a zero bit of the serial word, index wraps (32 -> 0)
    do_write(8'h00, 32'(SIDX), "R6 addr"); do_write(8'h04, 32'd32, "R6 bit wraps");
    do_write(8'h1C, 32'hFFFF_FFFF, "R6 program set"); do_read(8'h20, "R6 bit set");
    do_read(8'h1C, "R6 wen only bit0");
    do_write(8'h1C, 32'h0, "R6 wen zero no program"); do_read(8'h20, "R6 no change");

    // R8 redundancy select blocks, then a normal program succeeds
    do_write(8'h04, 32'd9, "R8 bit"); do_write(8'h08, 32'd0, "R8 din0");
    do_write(8'h18, 32'h4, "R8 red on"); do_write(8'h1C, 32'h1, "R8 blocked program");
    do_read(8'h20, "R8 unchanged");
    do_write(8'h18, 32'h0, "R8 red off"); do_write(8'h1C, 32'h1, "R8 flag was not set");
    do_read(8'h20, "R8 program after unblock");

    // R9 dout write ignored
    do_write(8'h20, 32'h0, "R9 dout write"); do_read(8'h20, "R9 dout unchanged");
    do_read(8'h00, "R9 addr unchanged");

    // R11 unmapped and unaligned
    do_read(8'h40, "R11 unmapped read"); do_read(8'h21, "R11 unaligned read");
    do_write(8'h38, 32'hDEAD_BEEF, "R11 unmapped write");
    do_write(8'h06, 32'h1234_5678, "R11 unaligned write");
    do_read(8'h04, "R11 bit unchanged"); do_read(8'h20, "R11 dout unchanged");

    // R10 plain storage
    do_write(8'h24, 32'hCAFE_0001, "R10 clkc"); do_write(8'h30, 32'h8000_0003, "R10 tstr");
    do_read(8'h24, "R10 clkc readback"); do_read(8'h30, "R10 tstr readback");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int k;
      k = int'($urandom_range(0, 11));
      case (k)
        0: do_write(8'h00, {$urandom_range(0, 255) > 200 ? 24'hABCDEF : 24'h0,
                            pick_idx[$urandom_range(0, 4)]}, "R5 rnd addr");
        1: do_write(8'h04, ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 31)),
                    "R6 rnd bit");
        2: do_write(8'h08, ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom, "R6 rnd din");
        3: do_write(8'h0C + 8'(4 * $urandom_range(0, 2)),
                    ($urandom_range(0, 3) == 0) ? 32'h0 : 32'h1, "R4 rnd enable");
        4: do_write(8'h18, ($urandom_range(0, 4) == 0) ? $urandom : 32'h0, "R8 rnd red");
        5, 6: do_write(8'h1C, $urandom, "R7 rnd program");
        7, 8: do_read(8'h20, "R4 R6 R7 rnd dout");
        9: do_read(8'(4 * $urandom_range(0, 13)), "R10 rnd readback");
        10: do_write(8'(4 * $urandom_range(9, 13)), $urandom, "R10 rnd plain");
        default: begin
          logic [7:0] o;
          o = 8'($urandom_range(0, 255));
          if ($urandom_range(0, 1) == 0) do_read(o, "R11 rnd offset read");
          else if (!is_mapped(o)) do_write(o, $urandom, "R11 rnd offset write");
        end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule